// File: doc/BRIEF.md
# Split-Enable 1K Work RAM Controller

This block serves a 1 KiB work RAM on a cartridge bus. The RAM is split into a lower and an upper 512-byte half. Each half has its own enable bit and its own write-protect bit, held in a small control register. A master RAM enable, taken from bit 5 of the mapper control byte, gates the whole function. The CPU reaches the RAM through a 4 KiB window in which the 1 KiB array repeats four times.

Each read of the window gets a response one clock later. The response is a data byte plus a drive flag. When the drive flag is low, the cartridge leaves the data bus open. When only one half is enabled, the disabled half returns zero bytes and the bus is still driven. When no half is enabled, or the master enable is off, the whole window floats.

Top module: `wram_split_ctrl`

## Requirements
- R1: Reset clears the master enable and all four control bits. While reset is held, and until the first request, `rsp_drive` and `rsp_data` are 0.
- R2: Addresses 7000h–7FFFh form the RAM window. The RAM byte is chosen by address bits 9:0, so the 1 KiB appears four times in the window.
- R3: A read of any address outside 7000h–7FFFh, including 6000h–6FFFh, gives `rsp_drive` = 0 and `rsp_data` = 00h.
- R4: A write to an address with bits 15:13 = 101b and bit 0 = 1 loads the control register from data bits 7:4: bit 7 = upper enable, bit 6 = upper write enable, bit 5 = lower enable, bit 4 = lower write enable. The write is ignored while the master enable is 0.
- R5: Address bit 9 selects the half: 0 is the lower half (offsets 000h–1FFh), 1 is the upper half (offsets 200h–3FFh).
- R6: A window write changes RAM only when the master enable, the half's enable and the half's write enable are all 1. The write-enable bit has no effect while its half is disabled.
- R7: If the master enable is 1 and exactly one half is enabled, a read of the other half is driven with data 00h, and a read of the enabled half returns the stored byte.
- R8: If the master enable is 0, or neither half is enabled, every window read gives `rsp_drive` = 0, whatever the write-enable bits hold.
- R9: A write to an address with bits 15:13 = 100b and bit 0 = 0 sets the master enable to data bit 5. When that bit is 1, the same write also clears all four control bits.
- R10: The response to a read appears on the clock edge after the request. On any cycle that follows a non-read cycle, `rsp_drive` = 0 and `rsp_data` = 00h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A CPU access is presented this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | CPU address |
| req_wdata | input | 8 | Write data |
| rsp_drive | output | 1 | Cartridge drives the bus with `rsp_data` |
| rsp_data | output | 8 | Read data (00h when not driven) |

## Verification
The assertions assume that the CPU presents at most one access per cycle. They also assume that `req_write`, `req_addr` and `req_wdata` are known whenever `req_valid` is high, and that reset is held for at least one clock. The bench changes inputs only on the falling clock edge and issues one request per call. Before any read can return stored data, it fills every RAM byte through the window, so no response depends on uninitialised storage. Random traffic is confined to the window, the 6000h range and the two register addresses, with arbitrary data bytes.

// File: rtl/wram_pkg.sv
package wram_pkg;

  typedef struct packed {
    logic hi_en;
    logic hi_we;
    logic lo_en;
    logic lo_we;
  } wram_ctl_t;

  function automatic logic half_open(input wram_ctl_t c, input logic master, input logic upper);
    return master && (upper ? c.hi_en : c.lo_en);
  endfunction

  function automatic logic half_writable(input wram_ctl_t c, input logic master, input logic upper);
    return half_open(c, master, upper) && (upper ? c.hi_we : c.lo_we);
  endfunction

  function automatic logic window_live(input wram_ctl_t c, input logic master);
    return master && (c.hi_en || c.lo_en);
  endfunction

endpackage

// File: rtl/wram_decode.sv
module wram_decode #(
  parameter int ADDR_W = 16,
  parameter int OFF_W  = 10,
  parameter logic [3:0] WIN_TAG = 4'h7
) (
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              mode_wr,
  output logic              ctl_wr,
  output logic              win_rd,
  output logic              win_wr,
  output logic [OFF_W-1:0]  offset
);
  logic in_win;

  always_comb begin
    in_win  = (req_addr[ADDR_W-1 -: 4] == WIN_TAG);
    mode_wr = req_valid && req_write && (req_addr[ADDR_W-1 -: 3] == 3'b100) && !req_addr[0];
    ctl_wr  = req_valid && req_write && (req_addr[ADDR_W-1 -: 3] == 3'b101) && req_addr[0];
    win_rd  = req_valid && !req_write && in_win;
    win_wr  = req_valid && req_write && in_win;
    offset  = req_addr[OFF_W-1:0];
  end
endmodule

// File: rtl/wram_regs.sv
module wram_regs
  import wram_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_wr,
  input  logic              ctl_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic              master,
  output wram_ctl_t         ctl
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      master <= 1'b0;
      ctl    <= '0;
    end else if (mode_wr) begin
      master <= wdata[5];
      if (wdata[5]) ctl <= '0;
    end else if (ctl_wr && master) begin
      ctl <= wram_ctl_t'(wdata[7:4]);
    end
  end

  // R9: enabling the RAM through the control byte wipes the half controls
  a_r9_enable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr && wdata[5] |=> (ctl == '0) && master);

  // R4: control writes bounce off while the master enable is low
  a_r4_locked_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !master && !mode_wr |=> $stable(ctl));
endmodule

// File: rtl/wram_store.sv
module wram_store #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 1024,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/wram_split_ctrl.sv
module wram_split_ctrl
  import wram_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int RAM_BYTES = 1024,
  localparam int OFF_W    = $clog2(RAM_BYTES),
  localparam int HALF_BIT = OFF_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_drive,
  output logic [DATA_W-1:0] rsp_data
);
  logic             mode_wr, ctl_wr, win_rd, win_wr;
  logic [OFF_W-1:0] offset;
  logic             master;
  wram_ctl_t        ctl;
  logic             upper;
  logic             mem_we;
  logic             drive_d, zero_d;
  logic             drive_q, zero_q;
  logic [DATA_W-1:0] store_q;

  wram_decode #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_decode (
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .mode_wr(mode_wr), .ctl_wr(ctl_wr), .win_rd(win_rd), .win_wr(win_wr),
    .offset(offset)
  );

  wram_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .ctl_wr(ctl_wr),
    .wdata(req_wdata), .master(master), .ctl(ctl)
  );

  always_comb begin
    upper   = offset[HALF_BIT];
    mem_we  = win_wr && half_writable(ctl, master, upper);
    drive_d = win_rd && window_live(ctl, master);
    zero_d  = !half_open(ctl, master, upper);
  end

  wram_store #(.DATA_W(DATA_W), .DEPTH(RAM_BYTES)) u_store (
    .clk(clk), .we(mem_we), .addr(offset), .wdata(req_wdata), .rdata(store_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      drive_q <= 1'b0;
      zero_q  <= 1'b1;
    end else begin
      drive_q <= drive_d;
      zero_q  <= zero_d;
    end
  end

  assign rsp_drive = drive_q;
  assign rsp_data  = (drive_q && !zero_q) ? store_q : '0;

  // R6: storage changes only for a window write while the master enable is on
  a_r6_write_needs_window: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> win_wr && master);

  // R10: the bus is driven only one cycle after a window read
  a_r10_drive_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_drive |-> $past(win_rd));

  // R8: no drive unless the master enable and some half enable were on at the request
  a_r8_float_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_drive |-> $past(master) && ($past(ctl.hi_en) || $past(ctl.lo_en)));

  // R3: an undriven response carries zero data
  a_r3_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_drive |-> rsp_data == '0);

  // R7: a read of a disabled half while the other is enabled returns zero
  a_r7_zero_half: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_drive && zero_q |-> rsp_data == '0);
endmodule

// File: tb/test_wram_split_ctrl.sv
module test_wram_split_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        rsp_drive;
  logic [7:0]  rsp_data;

  int checks = 0;
  int failures = 0;

  logic [7:0] mm [1024];
  logic       m_master = 1'b0;
  logic [3:0] m_ctl = '0;

  always #4 clk = ~clk;

  wram_split_ctrl i_wram_split_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_drive(rsp_drive), .rsp_data(rsp_data)
  );

  task automatic check(input string tag, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s drive/data actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic req(input string tag, input logic v, input logic w,
                     input logic [15:0] a, input logic [7:0] d);
    logic       e_drive;
    logic [7:0] e_data;
    logic       up, en, any;
    @(negedge clk);
    req_valid = v; req_write = w; req_addr = a; req_wdata = d;
    e_drive = 1'b0; e_data = 8'h00;
    up  = a[9];
    en  = m_master && (up ? m_ctl[3] : m_ctl[1]);
    any = m_master && (m_ctl[3] || m_ctl[1]);
    if (v && w) begin
      if (a[15:13] == 3'b100 && !a[0]) begin
        m_master = d[5];
        if (d[5]) m_ctl = '0;
      end else if (a[15:13] == 3'b101 && a[0]) begin
        if (m_master) m_ctl = d[7:4];
      end else if (a[15:12] == 4'h7) begin
        if (en && (up ? m_ctl[2] : m_ctl[0])) mm[a[9:0]] = d;
      end
    end else if (v && a[15:12] == 4'h7 && any) begin
      e_drive = 1'b1;
      e_data  = en ? mm[a[9:0]] : 8'h00;
    end
    @(posedge clk);
    #2;
    check(tag, {rsp_drive, rsp_data}, {e_drive, e_data});
  endtask

  task automatic rd(input string tag, input logic [15:0] a);
    req(tag, 1'b1, 1'b0, a, 8'h00);
  endtask

  task automatic wr(input string tag, input logic [15:0] a, input logic [7:0] d);
    req(tag, 1'b1, 1'b1, a, d);
  endtask

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check("R1", {rsp_drive, rsp_data}, 9'h000);
    @(negedge clk);
    rst_n = 1'b1;
    rd("R1", 16'h7000);
    wr("R4", 16'hA001, 8'hF0);
    wr("R9", 16'h8000, 8'h20);
    rd("R4", 16'h7000);
    wr("R4", 16'hA001, 8'hF0);
    for (int i = 0; i < 1024; i++)
      wr("R2", 16'h7000 + 16'(i) + 16'((i % 4) * 1024), 8'(i * 7 + 3));
    rd("R2", 16'h7C05);
    rd("R2", 16'h7405);
    rd("R2", 16'h7805);
    wr("R5", 16'h71FF, 8'hA5);
    wr("R5", 16'h7200, 8'h5A);
    rd("R5", 16'h71FF);
    rd("R5", 16'h7E00);
    wr("R6", 16'hA001, 8'hA0);
    wr("R6", 16'h7010, 8'h11);
    wr("R6", 16'h7210, 8'h22);
    rd("R6", 16'h7010);
    rd("R6", 16'h7210);
    wr("R6", 16'hA001, 8'hB0);
    wr("R6", 16'h7011, 8'h33);
    wr("R6", 16'h7211, 8'h44);
    rd("R6", 16'h7011);
    rd("R6", 16'h7211);
    wr("R6", 16'hA001, 8'h60);
    wr("R6", 16'h7212, 8'h55);
    wr("R7", 16'hA001, 8'h20);
    rd("R7", 16'h7300);
    rd("R7", 16'h7100);
    wr("R7", 16'hA001, 8'h80);
    rd("R7", 16'h7100);
    rd("R7", 16'h7300);
    rd("R6", 16'h7212);
    wr("R8", 16'hA001, 8'h50);
    wr("R8", 16'h7020, 8'hEE);
    wr("R8", 16'h7220, 8'hEE);
    rd("R8", 16'h7020);
    wr("R8", 16'hA001, 8'hF0);
    rd("R8", 16'h7020);
    rd("R8", 16'h7220);
    rd("R3", 16'h6000);
    rd("R3", 16'h6FFF);
    rd("R3", 16'h8000);
    rd("R3", 16'h5FFF);
    wr("R9", 16'h8000, 8'h27);
    rd("R9", 16'h7000);
    wr("R9", 16'hA001, 8'hF0);
    wr("R9", 16'h8000, 8'h06);
    rd("R9", 16'h7000);
    wr("R9", 16'h8000, 8'h20);
    rd("R9", 16'h7000);
    wr("R10", 16'hA001, 8'hF0);
    rd("R10", 16'h7001);
    req("R10", 1'b0, 1'b0, 16'h7001, 8'h00);
    req("R10", 1'b0, 1'b0, 16'h7001, 8'h00);
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] r;
      logic [15:0] a;
      r = $urandom;
      case (r[2:0])
        3'd0: a = 16'h8000;
        3'd1: a = 16'hA001;
        3'd2: a = 16'h6000 | 16'(r[19:8] & 12'hFFF);
        default: a = 16'h7000 | 16'(r[19:8] & 12'hFFF);
      endcase
      if (r[2:0] == 3'd0 && r[31:29] != 3'd0) a = 16'hA001;
      req("R10", r[28] | r[27], r[26], a, r[7:0] | 8'(r[25] ? 8'h20 : 8'h00));
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule